// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block models the device side of a small word-wide flash array together with the status its internal program/erase engine shows while it is working. A host issues one-cycle commands: program a word, erase one sector, or erase the whole array. While an operation runs, certain reads return a computed status word in place of stored data. A polling bit reports completion, and an error flag reports a timeout or a forbidden bit transition. A ready output goes low for the whole operation.

The array is built from registers inside the block. Erased words hold all ones. Programming can only turn ones into zeros, so the stored result is the AND of the old and new words. Trying to raise a zero to one is refused and puts the block into a sticky error state. The length of a program and of a sector erase, and the timeout limit, are parameters. A full-array erase lasts one sector erase time for every sector. Any operation whose length exceeds the timeout is aborted into the error state.

Top module: `flash_poll_model`

## Requirements
- R1: After reset `ready_o` is 1 and every address reads 16'hFFFF.
- R2: When a program command is accepted, `ready_o` is 0 for exactly PROG_CYCLES clock cycles after the accepting edge, and is 1 again after that.
- R3: A legal program leaves the target word holding the bitwise AND of its old value and the command data. A program is legal when the command data has no 1 in a bit position where the stored word has a 0.
- R4: While a program runs, a read of the target address returns a status word. Bit 7 is the inverse of data bit 7, bit 15 is the inverse of data bit 15, bits 5 and 13 are the error flag (0 while running), and all other bits are 0. Reads of any other address return stored data.
- R5: A sector erase keeps `ready_o` at 0 for SECT_ERASE_CYCLES cycles. It then sets every word of the sector, given by the top SECT_W address bits, to 16'hFFFF and leaves the other sectors unchanged.
- R6: While an erase runs, reads of even addresses in an affected sector return 16'h0000 (polling bits and error flag at 0). Odd addresses and unaffected sectors return stored data.
- R7: A full-array erase lasts SECT_ERASE_CYCLES times the number of sectors, treats every sector as affected, and then leaves every word at 16'hFFFF.
- R8: An illegal program changes no stored data. From the cycle after it is accepted, `ready_o` is 0 and reads of the target address return the R4 polling bits with bits 5 and 13 set.
- R9: An operation longer than TIMEOUT_CYCLES enters the error state TIMEOUT_CYCLES cycles after it is accepted. Its status reads then have bits 5 and 13 set, and the array keeps its previous contents.
- R10: The error state holds until `err_clr_i` is 1 at a clock edge. The next cycle `ready_o` is 1 and all reads return stored data.
- R11: Commands presented while `ready_o` is 0 are ignored.
- R12: The command code `cmd_op_i` is 2'b01 for program, 2'b10 for sector erase, 2'b11 for full-array erase, and 2'b00 for no operation (ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; erases the array |
| cmd_valid_i | input | 1 | Command strobe, sampled at the clock edge |
| cmd_op_i | input | 2 | Command code |
| cmd_addr_i | input | ADDR_W | Target word address (sector from its top bits) |
| cmd_data_i | input | 16 | Data to program |
| err_clr_i | input | 1 | Leaves the error state |
| rd_addr_i | input | ADDR_W | Read address (combinational read) |
| rd_data_o | output | 16 | Stored data or status word |
| ready_o | output | 1 | 1 when no operation is running and no error is held |

## Verification
Reads are combinational, so a status word or stored word is due in the same cycle its address is applied. A state change from the edge that accepts a command is visible one cycle after the command is driven. The bench drives and samples on falling edges. After issuing a command it counts falling edges: ready must still be low after the N-th edge following the accepting edge, and high after the (N+1)-th. A second instance with a short timeout makes the full-array erase abort. The bench samples its status on the cycle just before the abort edge and on the cycle just after it.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_PROG   = 2'b01,
    OP_SERASE = 2'b10,
    OP_CERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUSY = 2'b01,
    ST_ERR  = 2'b10
  } st_e;

  function automatic logic [DATA_W-1:0] stat_word(input logic p_hi, input logic p_lo,
                                                  input logic err);
    logic [DATA_W-1:0] w;
    w     = '0;
    w[15] = p_hi;
    w[7]  = p_lo;
    w[13] = err;
    w[5]  = err;
    return w;
  endfunction
endpackage

// File: rtl/flash_word_array.sv
module flash_word_array
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  erase_en_i,
  input  logic [(1<<SECT_W)-1:0] erase_mask_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [DATA_W-1:0]     rd_data_o,
  input  logic [ADDR_W-1:0]     sel_addr_i,
  output logic [DATA_W-1:0]     sel_data_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WA = ADDR_W'(w);
    localparam int SI = int'(WA[ADDR_W-1 -: SECT_W]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[w] <= '1;
      else if (erase_en_i && erase_mask_i[SI]) mem_q[w] <= '1;
      else if (wr_en_i && wr_addr_i == WA)     mem_q[w] <= wr_data_i;
    end
  end

  assign rd_data_o  = mem_q[rd_addr_i];
  assign sel_data_o = mem_q[sel_addr_i];
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W            = 6,
  parameter int SECT_W            = 2,
  parameter int PROG_CYCLES       = 8,
  parameter int SECT_ERASE_CYCLES = 32,
  parameter int TIMEOUT_CYCLES    = 256
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_valid_i,
  input  logic [1:0]             cmd_op_i,
  input  logic [ADDR_W-1:0]      cmd_addr_i,
  input  logic [DATA_W-1:0]      cmd_data_i,
  input  logic                   err_clr_i,
  input  logic [DATA_W-1:0]      old_word_i,
  output st_e                    st_o,
  output op_e                    op_o,
  output logic [ADDR_W-1:0]      tgt_addr_o,
  output logic [DATA_W-1:0]      tgt_data_o,
  output logic [(1<<SECT_W)-1:0] mask_o,
  output logic                   wr_en_o,
  output logic [DATA_W-1:0]      wr_data_o,
  output logic                   erase_en_o
);
  localparam int NSECT       = 1 << SECT_W;
  localparam int CHIP_CYCLES = SECT_ERASE_CYCLES * NSECT;
  localparam int MAX_A       = (PROG_CYCLES > CHIP_CYCLES) ? PROG_CYCLES : CHIP_CYCLES;
  localparam int MAX_C       = (MAX_A > TIMEOUT_CYCLES) ? MAX_A : TIMEOUT_CYCLES;
  localparam int CNT_W       = $clog2(MAX_C + 1);

  st_e                    st_q;
  op_e                    op_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [DATA_W-1:0]      data_q;
  logic [NSECT-1:0]       mask_q;
  logic [CNT_W-1:0]       cnt_q, dur_q;

  op_e                    op_in;
  logic                   accept, illegal, done, tmo;
  logic [CNT_W-1:0]       dur_in;
  logic [NSECT-1:0]       mask_in;

  assign op_in   = op_e'(cmd_op_i);
  assign accept  = cmd_valid_i && (st_q == ST_IDLE) && (op_in != OP_NONE);
  assign illegal = (op_in == OP_PROG) && (|(cmd_data_i & ~old_word_i));

  always_comb begin
    mask_in = '0;
    dur_in  = CNT_W'(PROG_CYCLES);
    unique case (op_in)
      OP_SERASE: begin
        mask_in[cmd_addr_i[ADDR_W-1 -: SECT_W]] = 1'b1;
        dur_in = CNT_W'(SECT_ERASE_CYCLES);
      end
      OP_CERASE: begin
        mask_in = '1;
        dur_in  = CNT_W'(CHIP_CYCLES);
      end
      default: ;
    endcase
  end

  // completion wins over timeout when both land on the same count
  assign done = (st_q == ST_BUSY) && (cnt_q == dur_q - 1'b1);
  assign tmo  = (st_q == ST_BUSY) && !done && (cnt_q == CNT_W'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
      cnt_q  <= '0;
      dur_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          op_q   <= op_in;
          addr_q <= cmd_addr_i;
          data_q <= cmd_data_i;
          mask_q <= mask_in;
          dur_q  <= dur_in;
          cnt_q  <= '0;
          st_q   <= illegal ? ST_ERR : ST_BUSY;
        end
        ST_BUSY: begin
          if (done)     st_q <= ST_IDLE;
          else if (tmo) st_q <= ST_ERR;
          else          cnt_q <= cnt_q + 1'b1;
        end
        ST_ERR: if (err_clr_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o       = st_q;
  assign op_o       = op_q;
  assign tgt_addr_o = addr_q;
  assign tgt_data_o = data_q;
  assign mask_o     = mask_q;
  assign wr_en_o    = done && (op_q == OP_PROG);
  assign wr_data_o  = old_word_i & data_q;
  assign erase_en_o = done && (op_q == OP_SERASE || op_q == OP_CERASE);
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2
) (
  input  st_e                    st_i,
  input  op_e                    op_i,
  input  logic [ADDR_W-1:0]      tgt_addr_i,
  input  logic [DATA_W-1:0]      tgt_data_i,
  input  logic [(1<<SECT_W)-1:0] mask_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  logic [DATA_W-1:0]      arr_data_i,
  output logic [DATA_W-1:0]      rd_data_o
);
  logic active, is_prog, hit_prog, hit_erase, err;

  assign active    = (st_i != ST_IDLE);
  assign is_prog   = (op_i == OP_PROG);
  assign err       = (st_i == ST_ERR);
  assign hit_prog  = is_prog && (rd_addr_i == tgt_addr_i);
  assign hit_erase = !is_prog && !rd_addr_i[0] && mask_i[rd_addr_i[ADDR_W-1 -: SECT_W]];

  always_comb begin
    rd_data_o = arr_data_i;
    if (active && hit_prog)
      rd_data_o = stat_word(~tgt_data_i[15], ~tgt_data_i[7], err);
    else if (active && hit_erase)
      rd_data_o = stat_word(1'b0, 1'b0, err);
  end
endmodule

// File: rtl/flash_poll_model.sv
module flash_poll_model
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W            = 6,
  parameter int SECT_W            = 2,
  parameter int PROG_CYCLES       = 8,
  parameter int SECT_ERASE_CYCLES = 32,
  parameter int TIMEOUT_CYCLES    = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [15:0]       cmd_data_i,
  input  logic              err_clr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [15:0]       rd_data_o,
  output logic              ready_o
);
  localparam int NSECT = 1 << SECT_W;

  st_e               st;
  op_e               op;
  logic [ADDR_W-1:0] tgt_addr, sel_addr;
  logic [DATA_W-1:0] tgt_data, sel_data, arr_data, wr_data;
  logic [NSECT-1:0]  mask;
  logic              wr_en, erase_en;

  assign sel_addr = (st == ST_IDLE) ? cmd_addr_i : tgt_addr;

  flash_word_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_arr (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(tgt_addr), .wr_data_i(wr_data),
    .erase_en_i(erase_en), .erase_mask_i(mask),
    .rd_addr_i, .rd_data_o(arr_data),
    .sel_addr_i(sel_addr), .sel_data_o(sel_data)
  );

  flash_op_seq #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYCLES(PROG_CYCLES),
    .SECT_ERASE_CYCLES(SECT_ERASE_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_seq (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_addr_i, .cmd_data_i, .err_clr_i,
    .old_word_i(sel_data), .st_o(st), .op_o(op), .tgt_addr_o(tgt_addr),
    .tgt_data_o(tgt_data), .mask_o(mask), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .erase_en_o(erase_en)
  );

  flash_read_mux #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_mux (
    .st_i(st), .op_i(op), .tgt_addr_i(tgt_addr), .tgt_data_i(tgt_data),
    .mask_i(mask), .rd_addr_i, .arr_data_i(arr_data), .rd_data_o
  );

  assign ready_o = (st == ST_IDLE);
endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_op_i,
  input logic              err_clr_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [15:0]       rd_data_o,
  input logic              ready_o,
  input st_e               st_i,
  input op_e               op_i,
  input logic [ADDR_W-1:0] tgt_addr_i,
  input logic [15:0]       tgt_data_i
);
  assert_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && ready_o && cmd_op_i != 2'b00) |=> !ready_o);

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ERR && !err_clr_i) |=> (st_i == ST_ERR && !ready_o));

  assert_err_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ERR && err_clr_i) |=> ready_o);

  assert_busy_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_BUSY && cmd_valid_i) |=> ($stable(tgt_addr_i) && $stable(op_i)));

  assert_poll_prog_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_BUSY && op_i == OP_PROG && rd_addr_i == tgt_addr_i)
      |-> (rd_data_o[7] != tgt_data_i[7] && rd_data_o[15] != tgt_data_i[15] && !rd_data_o[5]));
endmodule

bind flash_poll_model flash_poll_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .err_clr_i, .rd_addr_i, .rd_data_o, .ready_o,
  .st_i(st), .op_i(op), .tgt_addr_i(tgt_addr), .tgt_data_i(tgt_data)
);

// File: tb/flash_poll_model_test.sv
`timescale 1ns/1ps
module flash_poll_model_test;
  localparam int AW = 6;
  localparam int PC = 4;
  localparam int SE = 4;
  localparam int CE = SE * 4;
  localparam int TO_SHORT = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, err_clr = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [15:0] cmd_data = '0, rd_data, rd_data_to;
  logic ready, ready_to;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  flash_poll_model #(.ADDR_W(AW), .SECT_W(2), .PROG_CYCLES(PC), .SECT_ERASE_CYCLES(SE),
                     .TIMEOUT_CYCLES(64)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .err_clr_i(err_clr),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ready_o(ready));

  flash_poll_model #(.ADDR_W(AW), .SECT_W(2), .PROG_CYCLES(PC), .SECT_ERASE_CYCLES(SE),
                     .TIMEOUT_CYCLES(TO_SHORT)) uut_to (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .err_clr_i(err_clr),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data_to), .ready_o(ready_to));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns one falling edge after the accepting rising edge
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] v, output logic [15:0] vt);
    rd_addr = a;
    #1;
    v  = rd_data;
    vt = rd_data_to;
  endtask

  task automatic t_reset();
    logic [15:0] v, vt;
    chk("R1 ready", 16'(ready), 16'h1);
    rd(0, v, vt);  chk("R1 word0", v, 16'hFFFF);
    rd(37, v, vt); chk("R1 word37", v, 16'hFFFF);
    rd(63, v, vt); chk("R1 word63", v, 16'hFFFF);
  endtask

  task automatic t_noop();
    issue(2'b00, 5, 16'h0000);
    chk("R12 noop ready", 16'(ready), 16'h1);
  endtask

  task automatic t_program();
    logic [15:0] v, vt;
    issue(2'b01, 5, 16'h1234);
    rd(5, v, vt); chk("R4 status target", v, 16'h8080);
    rd(6, v, vt); chk("R4 other addr", v, 16'hFFFF);
    step(PC - 1); chk("R2 busy at end", 16'(ready), 16'h0);
    step(1);      chk("R2 ready after", 16'(ready), 16'h1);
    rd(5, v, vt); chk("R3 stored", v, 16'h1234);
    issue(2'b01, 7, 16'h0080);
    rd(7, v, vt); chk("R4 status bit7 set", v, 16'h8000);
    step(PC);
    rd(7, v, vt); chk("R3 stored 7", v, 16'h0080);
  endtask

  task automatic t_ignore();
    logic [15:0] v, vt;
    issue(2'b01, 5, 16'h1030);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = 5;  // erase while busy
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    step(PC - 2); chk("R11 busy", 16'(ready), 16'h0);
    step(1);      chk("R11 ready", 16'(ready), 16'h1);
    step(1);      chk("R11 no erase started", 16'(ready), 16'h1);
    rd(5, v, vt); chk("R3 and result", v, 16'h1030);
  endtask

  task automatic t_illegal();
    logic [15:0] v, vt;
    issue(2'b01, 5, 16'h1034);
    chk("R8 ready low", 16'(ready), 16'h0);
    rd(5, v, vt); chk("R8 err status", v, 16'hA0A0);
    step(10);
    chk("R10 still err", 16'(ready), 16'h0);
    rd(5, v, vt); chk("R10 err status held", v, 16'hA0A0);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R10 ready after clear", 16'(ready), 16'h1);
    rd(5, v, vt); chk("R8 array untouched", v, 16'h1030);
  endtask

  task automatic t_sector_erase();
    logic [15:0] v, vt;
    issue(2'b01, 18, 16'h00FF);
    rd(18, v, vt); chk("R4 status 18", v, 16'h8000);
    step(PC);
    issue(2'b10, 3, 16'h0000);
    rd(4, v, vt);  chk("R6 even in sector", v, 16'h0000);
    rd(5, v, vt);  chk("R6 odd in sector", v, 16'h1030);
    rd(18, v, vt); chk("R6 other sector", v, 16'h00FF);
    step(SE - 1);  chk("R5 busy", 16'(ready), 16'h0);
    step(1);       chk("R5 ready", 16'(ready), 16'h1);
    rd(5, v, vt);  chk("R5 erased 5", v, 16'hFFFF);
    rd(7, v, vt);  chk("R5 erased 7", v, 16'hFFFF);
    rd(18, v, vt); chk("R5 other kept", v, 16'h00FF);
  endtask

  task automatic t_chip_timeout();
    logic [15:0] v, vt;
    issue(2'b11, 0, 16'h0000);
    rd(18, v, vt);  chk("R7 status sector1", v, 16'h0000);
    step(TO_SHORT - 1);
    rd(18, v, vt);  chk("R9 before timeout", vt, 16'h0000);
    chk("R9 busy before timeout", 16'(ready_to), 16'h0);
    step(1);
    rd(18, v, vt);  chk("R9 timeout status", vt, 16'h2020);
    step(CE - TO_SHORT - 1);
    chk("R7 busy at end", 16'(ready), 16'h0);
    step(1);
    chk("R7 ready", 16'(ready), 16'h1);
    chk("R9 still err", 16'(ready_to), 16'h0);
    rd(18, v, vt);  chk("R7 erased 18", v, 16'hFFFF);
    rd(63, v, vt);  chk("R7 erased 63", v, 16'hFFFF);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R10 ready after timeout clear", 16'(ready_to), 16'h1);
    rd(18, v, vt);  chk("R9 array kept", vt, 16'h00FF);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_noop();
    t_program();
    t_ignore();
    t_illegal();
    t_sector_erase();
    t_chip_timeout();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule